// File: doc/BRIEF.md
# Sequential-Block Serial Register Slave

This block is a two-wire serial slave (I2C protocol, standard-mode timing) that holds a small bank of byte registers. It oversamples SCL and SDA with a fast system clock. It answers one fixed 7-bit address and never stretches the clock. Registers are not individually addressable. Every transfer walks the bank in order, from the lowest byte upward.

A write transfer carries two leading bytes: a command byte and a count byte. The slave acknowledges both and then throws them away. Every later byte fills registers 0, 1, 2 and so on. A read transfer first returns a byte count, then the register contents in order.

Two of the bytes drive the block's outputs. Byte 6 holds drive-strength flags, and its top bit is a read-only copy of an external mode pin. Byte 7 is a set of enable bits. The other bytes are plain storage.

Top module: `bseq_slave`

## Requirements
- R1: The slave pulls SDA low in the acknowledge slot only when the 7 address bits equal 1101001 (address byte 0xD2 for a write, 0xD3 for a read). Any other address gets no acknowledge, and the slave then stays silent until the next START.
- R2: In a write, the slave acknowledges the two bytes that follow the address (command, then count), and they change no register. The bytes after them go to register 0, then 1, then 2, in order.
- R3: In a read, the first byte returned is the byte count, 0x09. It is followed by register 0 upward. Every byte is sent MSB first, and each byte is acknowledged by the master.
- R4: If the master does not acknowledge a byte during a read, the slave releases SDA and drives nothing more until a new START.
- R5: A START (including a repeated START) or a STOP returns the byte position to the beginning. The next write again begins with the command byte, and the next read again begins with the count byte.
- R6: Bit 7 of byte 6 always reads as the level on `modePin`, and writes to that bit are ignored. Bit 4 of byte 6 is reserved: it reads 0 and ignores writes. Bits 6, 5 and 3..0 of byte 6 are writable.
- R7: After reset, registers 0 to 5, 7 and 8 hold 0xFF. Byte 6 holds 0 in bits 6..4 and 1 in bits 3..0, so with `modePin` high it reads 0x8F.
- R8: `ctrlByte` shows byte 6 as it reads over the bus, and `enableByte` shows byte 7. Both update once the data byte has been shifted in.
- R9: Data bytes written past register 8 are acknowledged and dropped. Reads past register 8 return 0x00.
- R10: The slave changes its SDA drive only while SCL is low, and it only ever pulls SDA low (open drain).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| modePin | input | 1 | External mode level mirrored into byte 6 bit 7 |
| sdaDriveLow | output | 1 | 1 pulls SDA low; 0 releases it |
| ctrlByte | output | 8 | Byte 6 as read back (drive flags, mode mirror) |
| enableByte | output | 8 | Byte 7 enable bits |

## Verification
The hardest situations to reach are the ones where the slave must stop talking or start over in the middle of a block. These are a master NACK partway through a read, a repeated START after a few data bytes, and a write that runs past the last register. Each one is produced by a bit-level bus master in the bench that controls every SCL and SDA edge. After a NACK, the master keeps clocking so the bench can see the slave stay released. After a repeated START, the master writes again and reads back which register the new byte reached. This shows that the byte position was reset.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX_ADDR,
    ST_ACK_ADDR,
    ST_RX_DATA,
    ST_ACK_DATA,
    ST_TX_DATA,
    ST_RX_MACK
  } bseqState_t;

  // strobes from the control FSM to the register datapath
  typedef struct packed {
    logic shiftIn;     // sample one SDA bit into the receive shifter
    logic commitByte;  // a received data byte is complete
    logic txLoad;      // load the next byte to transmit
    logic txShift;     // advance the transmit shifter by one bit
    logic idxClear;    // START or STOP seen: restart byte sequence
  } bseqStrobe_t;

  localparam int unsigned BITS_PER_BYTE = 8;

endpackage

// File: rtl/bseq_bank.sv
module bseq_bank
  import bseq_pkg::*;
#(
  parameter int unsigned NUM_REGS   = 9,
  parameter int unsigned CTRL_IDX   = 6,
  parameter int unsigned EN_IDX     = 7,
  parameter logic [7:0]  CTRL_RESET = 8'h0F,
  parameter logic [7:0]  CTRL_WMASK = 8'h6F,
  parameter logic [7:0]  COUNT_VAL  = 8'h09
) (
  input  logic        clk,
  input  logic        rstN,
  input  bseqStrobe_t strobe,
  input  logic        sdaBit,
  input  logic        modePin,
  output logic [7:0]  rxByte,
  output logic        txBit,
  output logic [7:0]  ctrlByte,
  output logic [7:0]  enableByte
);

  localparam int unsigned CNT_W = $clog2(NUM_REGS + 3) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_REGS-1:0][7:0] regFile;
  logic [NUM_REGS-1:0][7:0] readView;
  logic [CNT_W-1:0]         xferCnt;
  logic [7:0]               txByte;
  logic [7:0]               txNext;

  // one storage byte per register; byte CTRL_IDX has a write mask
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] RST_VAL = (g == CTRL_IDX) ? CTRL_RESET : 8'hFF;
    localparam logic [7:0] WMASK   = (g == CTRL_IDX) ? CTRL_WMASK : 8'hFF;
    logic [7:0] store;
    logic       hit;
    assign hit = strobe.commitByte && (xferCnt == CNT_W'(g + 2));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)    store <= RST_VAL;
      else if (hit) store <= (store & ~WMASK) | (rxByte & WMASK);
    end
    assign regFile[g] = store;
    if (g == CTRL_IDX) begin : g_mirror
      assign readView[g] = {modePin, store[6:0]};
    end else begin : g_plain
      assign readView[g] = store;
    end
  end

  // byte position within the current transfer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xferCnt <= '0;
    end else if (strobe.idxClear) begin
      xferCnt <= '0;
    end else if ((strobe.commitByte || strobe.txLoad) && xferCnt != CNT_MAX) begin
      xferCnt <= xferCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rxByte <= '0;
    else if (strobe.shiftIn) rxByte <= {rxByte[6:0], sdaBit};
  end

  always_comb begin
    txNext = 8'h00;
    if (xferCnt == '0) begin
      txNext = COUNT_VAL;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (xferCnt == CNT_W'(i + 1)) txNext = readView[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               txByte <= 8'hFF;
    else if (strobe.txLoad)  txByte <= txNext;
    else if (strobe.txShift) txByte <= {txByte[6:0], 1'b1};
  end

  assign txBit      = txByte[7];
  assign ctrlByte   = readView[CTRL_IDX];
  assign enableByte = readView[EN_IDX];

  p_cmd_count_ignored_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commitByte && xferCnt < CNT_W'(2)) |=> $stable(regFile));

  p_count_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.txLoad && xferCnt == '0) |=> (txByte == COUNT_VAL));

  p_idx_restart_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.idxClear |=> (xferCnt == '0));

  p_overrun_dropped_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commitByte && xferCnt >= CNT_W'(NUM_REGS + 2)) |=> $stable(regFile));

endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1101001
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [7:0]  rxByte,
  input  logic        txBit,
  output bseqStrobe_t strobe,
  output logic        sdaBit,
  output logic        sdaDriveLow
);

  localparam logic [3:0] FULL_BYTE = 4'(BITS_PER_BYTE);

  logic [1:0]  sclSync, sdaSync;
  logic        sclD, sdaD, sclS, sdaS;
  logic        sclRise, sclFall, startDet, stopDet;
  bseqState_t  state;
  logic [3:0]  bitCnt;
  logic        readMode;
  logic        masterAck;
  logic        addrMatch;

  // two-flop synchronisers plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclD    <= sclSync[1];
      sdaD    <= sdaSync[1];
    end
  end

  assign sclS     = sclSync[1];
  assign sdaS     = sdaSync[1];
  assign sclRise  = sclS && !sclD;
  assign sclFall  = !sclS && sclD;
  assign startDet = sclS && sclD && sdaD && !sdaS;
  assign stopDet  = sclS && sclD && !sdaD && sdaS;
  assign addrMatch = (rxByte[7:1] == DEV_ADDR);
  assign sdaBit   = sdaS;

  always_comb begin
    strobe = '0;
    strobe.idxClear = startDet || stopDet;
    if (!startDet && !stopDet) begin
      unique case (state)
        ST_RX_ADDR:  strobe.shiftIn = sclRise;
        ST_RX_DATA: begin
          strobe.shiftIn    = sclRise;
          strobe.commitByte = sclFall && (bitCnt == FULL_BYTE);
        end
        ST_ACK_ADDR: strobe.txLoad  = sclFall && readMode;
        ST_TX_DATA:  strobe.txShift = sclFall && (bitCnt != FULL_BYTE);
        ST_RX_MACK:  strobe.txLoad  = sclFall && masterAck;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      readMode  <= 1'b0;
      masterAck <= 1'b0;
    end else if (stopDet) begin
      state <= ST_IDLE;
    end else if (startDet) begin
      state  <= ST_RX_ADDR;
      bitCnt <= '0;
    end else begin
      unique case (state)
        ST_RX_ADDR: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 1'b1;
          end else if (sclFall && bitCnt == FULL_BYTE) begin
            if (addrMatch) begin
              readMode <= rxByte[0];
              state    <= ST_ACK_ADDR;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ACK_ADDR: begin
          if (sclFall) begin
            bitCnt <= '0;
            state  <= readMode ? ST_TX_DATA : ST_RX_DATA;
          end
        end
        ST_RX_DATA: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          else if (sclFall && bitCnt == FULL_BYTE) state <= ST_ACK_DATA;
        end
        ST_ACK_DATA: begin
          if (sclFall) begin
            bitCnt <= '0;
            state  <= ST_RX_DATA;
          end
        end
        ST_TX_DATA: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          else if (sclFall && bitCnt == FULL_BYTE) state <= ST_RX_MACK;
        end
        ST_RX_MACK: begin
          if (sclRise) begin
            masterAck <= !sdaS;
          end else if (sclFall) begin
            if (masterAck) begin
              bitCnt <= '0;
              state  <= ST_TX_DATA;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sdaDriveLow = (state == ST_ACK_ADDR) || (state == ST_ACK_DATA) ||
                       ((state == ST_TX_DATA) && !txBit);

  p_ack_needs_match_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACK_ADDR) |-> (rxByte[7:1] == DEV_ADDR));

  p_nack_ends_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RX_MACK && sclFall && !masterAck && !startDet && !stopDet)
      |=> (state == ST_IDLE && !sdaDriveLow));

  p_sda_hold_scl_high_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && $past(sclS)) |-> $stable(sdaDriveLow));

endmodule

// File: rtl/bseq_slave.sv
module bseq_slave
  import bseq_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR  = 7'b1101001,
  parameter int unsigned NUM_REGS  = 9,
  parameter logic [7:0]  COUNT_VAL = 8'h09
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       modePin,
  output logic       sdaDriveLow,
  output logic [7:0] ctrlByte,
  output logic [7:0] enableByte
);

  bseqStrobe_t strobe;
  logic [7:0]  rxByte;
  logic        txBit;
  logic        sdaBit;

  bseq_ctrl #(
    .DEV_ADDR (DEV_ADDR)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (sclIn),
    .sdaIn       (sdaIn),
    .rxByte      (rxByte),
    .txBit       (txBit),
    .strobe      (strobe),
    .sdaBit      (sdaBit),
    .sdaDriveLow (sdaDriveLow)
  );

  bseq_bank #(
    .NUM_REGS   (NUM_REGS),
    .CTRL_IDX   (6),
    .EN_IDX     (7),
    .CTRL_RESET (8'h0F),
    .CTRL_WMASK (8'h6F),
    .COUNT_VAL  (COUNT_VAL)
  ) u_bank (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .sdaBit     (sdaBit),
    .modePin    (modePin),
    .rxByte     (rxByte),
    .txBit      (txBit),
    .ctrlByte   (ctrlByte),
    .enableByte (enableByte)
  );

endmodule

// File: tb/test_bseq_slave.sv
module test_bseq_slave;

  localparam int Q = 20;  // system clocks per quarter bit

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic modePin = 1'b1;
  logic sdaDriveLow;
  logic sdaBus;
  logic [7:0] ctrlByte, enableByte;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] expRegs [9];

  always #10 clk = ~clk;
  assign sdaBus = mSda & ~sdaDriveLow;

  bseq_slave i_bseq_slave (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus), .modePin(modePin),
    .sdaDriveLow(sdaDriveLow), .ctrlByte(ctrlByte), .enableByte(enableByte)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; waitQ(); mScl = 1'b1; waitQ(); mSda = 1'b0; waitQ(); mScl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    mSda = 1'b0; waitQ(); mScl = 1'b1; waitQ(); mSda = 1'b1; waitQ();
  endtask

  task automatic writeBit(input logic b);
    mSda = b; waitQ(); mScl = 1'b1; waitQ(); waitQ(); mScl = 1'b0; waitQ();
  endtask

  task automatic readBit(output logic b);
    mSda = 1'b1; waitQ(); mScl = 1'b1; waitQ(); b = sdaBus; waitQ(); mScl = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] v, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(a);
    acked = !a;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin readBit(b); v[i] = b; end
    writeBit(!ackIt);
  endtask

  function automatic logic [7:0] viewOf(input int i);
    return (i == 6) ? {modePin, expRegs[6][6:0]} : expRegs[i];
  endfunction

  // write transaction: address, command, count, then n data bytes
  task automatic writeBlock(input logic [7:0] data [12], input int n, input string tag);
    logic ack;
    busStart();
    sendByte(8'hD2, ack); chk({tag, " R1 write addr ack"}, ack, 1);
    sendByte(8'h5C, ack); chk({tag, " R2 command ack"}, ack, 1);
    sendByte(8'h3E, ack); chk({tag, " R2 count ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      sendByte(data[i], ack);
      chk({tag, (i >= 9) ? " R9 overrun ack" : " R2 data ack"}, ack, 1);
      if (i < 9) expRegs[i] = (i == 6) ? (data[i] & 8'h6F) : data[i];
    end
    busStop();
  endtask

  // read transaction: count byte, all registers, then extra bytes past the end
  task automatic readBlock(input int extra, input string tag);
    logic ack;
    logic [7:0] v;
    busStart();
    sendByte(8'hD3, ack); chk({tag, " R1 read addr ack"}, ack, 1);
    recvByte(1'b1, v); chk({tag, " R3 count byte"}, v, 8'h09);
    for (int i = 0; i < 9; i++) begin
      recvByte(!(extra == 0 && i == 8), v);
      chk($sformatf("%s R3 R6 reg%0d", tag, i), v, viewOf(i));
    end
    for (int i = 0; i < extra; i++) begin
      recvByte(i != extra - 1, v); chk({tag, " R9 read past end"}, v, 8'h00);
    end
    busStop();
  endtask

  task automatic tReset();
    chk("R7 R8 reset ctrlByte", ctrlByte, 8'h8F);
    chk("R7 R8 reset enableByte", enableByte, 8'hFF);
    chk("R10 reset sda released", sdaDriveLow, 0);
    readBlock(0, "reset");
  endtask

  task automatic tWrongAddr();
    logic ack;
    busStart();
    sendByte(8'hA0, ack); chk("R1 foreign address no ack", ack, 0);
    sendByte(8'h00, ack); chk("R1 silent after foreign address", ack, 0);
    busStop();
    busStart();
    sendByte(8'hD0, ack); chk("R1 near address no ack", ack, 0);
    busStop();
  endtask

  task automatic tWriteRead();
    logic [7:0] d [12];
    for (int i = 0; i < 12; i++) d[i] = 8'h30 + 8'(i);
    d[6] = 8'hF0;  // bit7 and reserved bit4 must be dropped
    d[7] = 8'h5A;
    writeBlock(d, 9, "block");
    repeat (4) @(negedge clk);
    chk("R6 R8 ctrlByte after write", ctrlByte, 8'hE0);
    chk("R8 enableByte after write", enableByte, 8'h5A);
    readBlock(0, "block");
  endtask

  task automatic tNackEnds();
    logic ack, b;
    logic [7:0] v;
    int ones = 0;
    busStart();
    sendByte(8'hD3, ack); chk("R4 addr ack", ack, 1);
    recvByte(1'b1, v); chk("R4 count", v, 8'h09);
    recvByte(1'b0, v); chk("R4 byte0 before nack", v, expRegs[0]);
    for (int i = 0; i < 9; i++) begin readBit(b); ones += int'(b); end
    chk("R4 slave silent after nack", ones, 9);
    busStop();
    busStart();
    sendByte(8'hD3, ack);
    recvByte(1'b0, v); chk("R5 count after stop", v, 8'h09);
    busStop();
  endtask

  task automatic tOverrun();
    logic [7:0] d [12];
    for (int i = 0; i < 12; i++) d[i] = 8'hA0 + 8'(i);
    writeBlock(d, 11, "overrun");
    readBlock(2, "overrun");
  endtask

  task automatic tRestart();
    logic ack;
    logic [7:0] v;
    busStart();
    sendByte(8'hD2, ack); sendByte(8'h01, ack); sendByte(8'h02, ack);
    sendByte(8'h77, ack); sendByte(8'h78, ack);
    busStart();  // repeated start
    sendByte(8'hD2, ack); chk("R5 addr after restart", ack, 1);
    sendByte(8'h01, ack); sendByte(8'h02, ack);
    sendByte(8'h44, ack);
    busStart();  // repeated start into a read
    sendByte(8'hD3, ack);
    recvByte(1'b1, v); chk("R5 count after restart", v, 8'h09);
    recvByte(1'b1, v); chk("R5 reg0 from second write", v, 8'h44);
    recvByte(1'b0, v); chk("R5 reg1 from first write", v, 8'h78);
    busStop();
    expRegs[0] = 8'h44;
    expRegs[1] = 8'h78;
  endtask

  task automatic tModePin();
    logic [7:0] d [12];
    modePin = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 ctrlByte mirrors low pin", ctrlByte[7], 0);
    for (int i = 0; i < 12; i++) d[i] = expRegs[i < 9 ? i : 0];
    d[6] = 8'hFF;
    writeBlock(d, 7, "mode");
    repeat (4) @(negedge clk);
    chk("R6 bit7 write ignored", ctrlByte, 8'h6F);
    readBlock(0, "mode");
    modePin = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 ctrlByte mirrors high pin", ctrlByte, 8'hEF);
  endtask

  initial begin
    for (int i = 0; i < 9; i++) expRegs[i] = 8'hFF;
    expRegs[6] = 8'h0F;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    tReset();
    tWrongAddr();
    tWriteRead();
    tNackEnds();
    tOverrun();
    tRestart();
    tModePin();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule